// File: doc/BRIEF.md
# Sensor Status SPI Slave

This block is the serial front end of a touch position sensor. A host frames each exchange by pulling select low and clocking eight bits. The block takes in a command byte on MOSI and, in the same clocks, returns a status byte on MISO. The status byte does not depend on the command. It carries a touch flag. With a touch, the rest of the byte is a 7-bit position. Without one, it is a sensor-type bit followed by zeros. The result it reports comes from the detection that was current when select fell. Each exchange therefore returns the outcome of the burst that the previous exchange started.

All serial inputs are brought into the system clock domain through multi-flop synchronisers. The block detects edges there. It samples MOSI on a rising serial clock edge and advances MISO on a falling edge, both MSB first. If the host keeps clocking past eight bits, the status byte goes out again and again. A busy/ready input from the sensor core gates every edge. A rising serial clock edge that arrives while the core is busy is dropped and flagged. When select rises after a complete and clean byte, the block latches the command and pulses a one-cycle flag. The burst sequencer uses that flag as its trigger, and the null command 0x00 counts like any other command.

Top module: `sensor_spi_slave`

## Requirements
- R1: On each accepted rising edge of `sclk_i` inside a frame, the block shifts the `mosi_i` bit in, MSB first. When the frame closes, `cmd_o` holds the last eight bits received, with the first of those eight bits in bit 7.
- R2: The block presents bit 7 of the status byte on `miso_o` before the first rising edge of `sclk_i`. After each accepted falling edge, `miso_o` moves to the next lower bit.
- R3: With `touch_i` low, the status byte has bit 7 = 0 and bit 6 = parameter `WHEEL` (0 for a linear sensor, 1 for a wheel). Bits 5 to 0 are 0.
- R4: With `touch_i` high, the status byte has bit 7 = 1, and bits 6 to 0 equal `position_i`.
- R5: The block captures the status byte when select falls. Changes on `touch_i` or `position_i` later in the frame do not alter what `miso_o` sends in that frame.
- R6: If a frame has more than eight clocks, the status byte repeats on `miso_o` in a circle, and `cmd_o` gets the last eight bits.
- R7: When `ss_n_i` rises after at least eight accepted bits and no framing error, `cmd_valid_o` pulses high for exactly one cycle. In that same cycle `cmd_o` takes the new command, and this holds for 0x00 as well.
- R8: A frame that closes with fewer than eight accepted bits gives no `cmd_valid_o` pulse, and `cmd_o` keeps its previous value.
- R9: A rising `sclk_i` edge in a frame while `ready_i` is low does not shift. It pulses `frame_err_o` for one cycle, and that frame gives no `cmd_valid_o`.
- R10: After reset, and whenever no frame is open, `miso_o`, `cmd_valid_o` and `frame_err_o` are 0. After reset, `cmd_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host, idle low |
| ss_n_i | input | 1 | Frame select from host, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| ready_i | input | 1 | Sensor core ready; low means busy |
| touch_i | input | 1 | Latest detection: touched |
| position_i | input | 7 | Latest calculated position |
| cmd_o | output | 8 | Last completed command byte |
| cmd_valid_o | output | 1 | One-cycle pulse when a command completes |
| frame_err_o | output | 1 | One-cycle pulse per serial clock edge dropped while busy |

## Verification
A wrong bit counter shows up within one frame. Either `cmd_valid_o` fires after a short frame, or it stays silent after a full one. A rotation fault in the transmit register shows up within one or two bytes, because the wrong MISO bits appear, most clearly in the second byte of a 16-clock frame. A stale busy gate shows up as a missing or extra `frame_err_o` pulse on the very edge concerned, and a command lands although it should not. Detection changes made inside a frame reveal late capture of the status byte on the next MISO bit.

// File: rtl/spi_resp_pkg.sv
package spi_resp_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned POS_W  = 7;
  localparam logic [BYTE_W-1:0] CMD_NULL = 8'h00;

  // Status byte: touch flag on top; position below it, or type bit and zeros.
  function automatic logic [BYTE_W-1:0] status_byte(
    input logic             touched,
    input logic [POS_W-1:0] pos,
    input logic             wheel
  );
    logic [BYTE_W-1:0] b;
    if (touched) b = {1'b1, pos};
    else         b = {1'b0, wheel, {(BYTE_W-2){1'b0}}};
    return b;
  endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] &  pipe_q[STAGES];

endmodule

// File: rtl/shift_core.sv
module shift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic              close_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] resp_i,
  output logic              miso_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              cmd_valid_o,
  output logic              frame_err_o,
  output logic              active_o,
  output logic              fall_ok_o,
  output logic [$clog2(DATA_W+1)-1:0] cnt_o
);

  localparam int unsigned CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] FULL = CW'(DATA_W);

  logic              active_q, active_d, active_en;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              cnt_en;
  logic              bad_q, bad_d, bad_en;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              rx_en;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              tx_en;
  logic [DATA_W-1:0] cmd_q;
  logic              cmd_en;
  logic              valid_q, valid_d;
  logic              err_q, err_d;
  logic              rise_ok, rise_bad, fall_ok, done;

  always_comb begin
    rise_ok  = rise_i & active_q &  ready_i;
    rise_bad = rise_i & active_q & ~ready_i;
    fall_ok  = fall_i & active_q &  ready_i;
    done     = close_i & active_q & (cnt_q == FULL) & ~bad_q;

    active_en = open_i | close_i;
    active_d  = open_i;

    cnt_en = open_i | (rise_ok & (cnt_q != FULL));
    cnt_d  = open_i ? '0 : cnt_q + 1'b1;

    bad_en = open_i | rise_bad;
    bad_d  = ~open_i;

    rx_en = rise_ok;
    rx_d  = {rx_q[DATA_W-2:0], mosi_i};

    tx_en = open_i | fall_ok;
    tx_d  = open_i ? resp_i : {tx_q[DATA_W-2:0], tx_q[DATA_W-1]};

    cmd_en  = done;
    valid_d = done;
    err_d   = rise_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bad_q    <= 1'b0;
      rx_q     <= '0;
      tx_q     <= '0;
      cmd_q    <= '0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (active_en) active_q <= active_d;
      if (cnt_en)    cnt_q    <= cnt_d;
      if (bad_en)    bad_q    <= bad_d;
      if (rx_en)     rx_q     <= rx_d;
      if (tx_en)     tx_q     <= tx_d;
      if (cmd_en)    cmd_q    <= rx_q;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign miso_o      = active_q & tx_q[DATA_W-1];
  assign cmd_o       = cmd_q;
  assign cmd_valid_o = valid_q;
  assign frame_err_o = err_q;
  assign active_o    = active_q;
  assign fall_ok_o   = fall_ok;
  assign cnt_o       = cnt_q;

endmodule

// File: rtl/sensor_spi_slave.sv
module sensor_spi_slave #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        WHEEL       = 1'b0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sclk_i,
  input  logic                             ss_n_i,
  input  logic                             mosi_i,
  output logic                             miso_o,
  input  logic                             ready_i,
  input  logic                             touch_i,
  input  logic [spi_resp_pkg::POS_W-1:0]   position_i,
  output logic [spi_resp_pkg::BYTE_W-1:0]  cmd_o,
  output logic                             cmd_valid_o,
  output logic                             frame_err_o
);

  import spi_resp_pkg::*;

  localparam int unsigned NSIG = 3;       // 0: sclk, 1: select, 2: mosi
  localparam logic [NSIG-1:0] RST_PAT = 3'b010;
  localparam int unsigned CW = $clog2(BYTE_W + 1);

  logic [NSIG-1:0] raw_in, lvl, rise, fall;
  logic [BYTE_W-1:0] resp;
  logic active, fall_ok;
  logic [CW-1:0] bit_cnt;

  assign raw_in = {mosi_i, ss_n_i, sclk_i};

  for (genvar i = 0; i < NSIG; i++) begin : g_sync
    sync_edge #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(RST_PAT[i])
    ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (raw_in[i]),
      .level_o(lvl[i]),
      .rise_o (rise[i]),
      .fall_o (fall[i])
    );
  end

  always_comb begin
    resp = status_byte(touch_i, position_i, WHEEL);
  end

  shift_core #(
    .DATA_W(BYTE_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_i     (fall[1]),
    .close_i    (rise[1]),
    .rise_i     (rise[0]),
    .fall_i     (fall[0]),
    .mosi_i     (lvl[2]),
    .ready_i    (ready_i),
    .resp_i     (resp),
    .miso_o     (miso_o),
    .cmd_o      (cmd_o),
    .cmd_valid_o(cmd_valid_o),
    .frame_err_o(frame_err_o),
    .active_o   (active),
    .fall_ok_o  (fall_ok),
    .cnt_o      (bit_cnt)
  );

endmodule

// File: rtl/sensor_spi_slave_chk.sv
module sensor_spi_slave_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready_i,
  input logic              miso_o,
  input logic [BYTE_W-1:0] cmd_o,
  input logic              cmd_valid_o,
  input logic              frame_err_o,
  input logic              active,
  input logic              fall_ok,
  input logic [CW-1:0]     bit_cnt
);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  a_r7_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> bit_cnt == CW'(BYTE_W));

  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_o) |-> cmd_valid_o);

  a_r9_err_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> $past(!ready_i));

  a_r2_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(miso_o)) |-> $past(fall_ok));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !frame_err_o);

endmodule

bind sensor_spi_slave sensor_spi_slave_chk #(
  .BYTE_W(spi_resp_pkg::BYTE_W),
  .CW    ($clog2(spi_resp_pkg::BYTE_W + 1))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready_i    (ready_i),
  .miso_o     (miso_o),
  .cmd_o      (cmd_o),
  .cmd_valid_o(cmd_valid_o),
  .frame_err_o(frame_err_o),
  .active     (active),
  .fall_ok    (fall_ok),
  .bit_cnt    (bit_cnt)
);

// File: tb/sensor_spi_slave_tb.sv
module sensor_spi_slave_tb;

  localparam int HALF = 10;  // system clocks per serial half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0, ready = 1'b1;
  logic       touch = 1'b0;
  logic [6:0] pos = 7'd0;
  logic       miso_l, miso_w;
  logic [7:0] cmd_l, cmd_w;
  logic       val_l, val_w, err_l, err_w;

  int checks = 0, errors = 0;
  int valid_cnt = 0, err_cnt = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  sensor_spi_slave #(.WHEEL(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ss_n_i(ss_n), .mosi_i(mosi),
    .miso_o(miso_l), .ready_i(ready), .touch_i(touch), .position_i(pos),
    .cmd_o(cmd_l), .cmd_valid_o(val_l), .frame_err_o(err_l));

  sensor_spi_slave #(.WHEEL(1'b1)) u_dut_wheel (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ss_n_i(ss_n), .mosi_i(mosi),
    .miso_o(miso_w), .ready_i(ready), .touch_i(touch), .position_i(pos),
    .cmd_o(cmd_w), .cmd_valid_o(val_w), .frame_err_o(err_w));

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every command pulse.
  always @(negedge clk) begin
    if (rst_n) begin
      if (err_l) err_cnt++;
      if (val_l) begin
        valid_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected cmd", {8'h0, cmd_l}, 16'h0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(cmd_l == e, "R1/R7 cmd", {8'h0, cmd_l}, {8'h0, e});
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one framed exchange; expected status computed from inputs at open.
  task automatic xfer(input logic [15:0] word, input int nbits, input bit chg_mid,
                      input bit exp_valid, input string tag);
    logic [7:0]  exp_l, exp_w;
    logic [15:0] got_l, got_w;
    int v0;
    exp_l = touch ? {1'b1, pos} : 8'h00;
    exp_w = touch ? {1'b1, pos} : 8'h40;
    got_l = '0; got_w = '0;
    v0 = valid_cnt;
    if (exp_valid) exp_q.push_back(word[7:0]);
    ss_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[nbits-1-i];
      tick(HALF);
      got_l = {got_l[14:0], miso_l};
      got_w = {got_w[14:0], miso_w};
      sclk = 1'b1;
      if (chg_mid && i == 0) begin touch = ~touch; pos = ~pos; end
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    ss_n = 1'b1;
    tick(12);
    if (nbits >= 8 && ready) begin
      check(got_l[7:0] == exp_l, {tag, " linear byte"}, {8'h0, got_l[7:0]}, {8'h0, exp_l});
      check(got_w[7:0] == exp_w, {tag, " wheel byte"}, {8'h0, got_w[7:0]}, {8'h0, exp_w});
    end
    if (nbits == 16) begin
      check(got_l[15:8] == exp_l, "R6 repeat linear", {8'h0, got_l[15:8]}, {8'h0, exp_l});
      check(got_w[15:8] == exp_w, "R6 repeat wheel", {8'h0, got_w[15:8]}, {8'h0, exp_w});
    end
    check((valid_cnt - v0) == int'(exp_valid), {tag, " pulse count R7/R8"},
          16'(valid_cnt - v0), 16'(exp_valid));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 16'h0, 16'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int e0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R10 reset state
    check(miso_l == 1'b0 && miso_w == 1'b0, "R10 idle miso", {15'h0, miso_l}, 16'h0);
    check(cmd_l == 8'h00 && !val_l && !err_l, "R10 reset outputs", {8'h0, cmd_l}, 16'h0);

    // R3 no touch, R11-style null command counted as command (R7)
    touch = 1'b0; pos = 7'h2A;
    xfer(16'h0000, 8, 1'b0, 1'b1, "R3 null");
    // R4 touch patterns, R1 command capture
    touch = 1'b1; pos = 7'h55;
    xfer(16'h00A7, 8, 1'b0, 1'b1, "R4 pos55");
    pos = 7'h7F;
    xfer(16'h0031, 8, 1'b0, 1'b1, "R4 pos7F");
    pos = 7'h00;
    xfer(16'h00C2, 8, 1'b0, 1'b1, "R4 pos00");
    // R5 inputs change mid-frame
    touch = 1'b1; pos = 7'h13;
    xfer(16'h005E, 8, 1'b1, 1'b1, "R5 latch");
    // R6 sixteen clocks
    touch = 1'b0;
    xfer(16'h3C96, 16, 1'b0, 1'b1, "R6 long");
    // R8 partial frame
    xfer(16'h0015, 5, 1'b0, 1'b0, "R8 partial");
    check(cmd_l == 8'h96, "R8 cmd kept", {8'h0, cmd_l}, 16'h0096);
    // R9 busy frame
    e0 = err_cnt;
    ready = 1'b0;
    xfer(16'h00E1, 8, 1'b0, 1'b0, "R9 busy");
    ready = 1'b1;
    check((err_cnt - e0) == 8, "R9 error pulses", 16'(err_cnt - e0), 16'd8);
    check(cmd_l == 8'h96, "R9 cmd kept", {8'h0, cmd_l}, 16'h0096);
    // R10 idle after frames
    check(miso_l == 1'b0 && miso_w == 1'b0, "R10 idle miso after", {15'h0, miso_w}, 16'h0);
    // recovery after error frame
    touch = 1'b1; pos = 7'h6B;
    xfer(16'h004D, 8, 1'b0, 1'b1, "R1 recover");
    check(exp_q.size() == 0, "R7 scoreboard drained", 16'(exp_q.size()), 16'h0);
    check(valid_cnt == 7, "R7 total pulses", 16'(valid_cnt), 16'd7);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule